// File: doc/BRIEF.md
# USB Device Suspend and Wake-up Sequencer

This block controls how a full-speed USB device enters suspend and how it wakes up again. Firmware writes a small set of control registers. Suspend is entered when the go-suspend control bit goes from 1 to 0. While suspended, the oscillator is disabled and the internal clocks are gated off. An optional power-off indication is raised if the configuration asks for it.

Three sources can end suspend: a K-state driven by the host on the bus, a HIGH level on the wake pin, or a LOW level on chip-select. Chip-select counts only when it has been enabled in the configuration register. A wake request starts a fixed sequence. The oscillator is enabled first. The sequencer then waits for a clock-stable indication, with a bounded timeout. When the clocks are routed back, the suspend output falls and the resume flag is raised. If the wake came from the application, the block also drives a K-state on the bus for a fixed number of cycles. Firmware can request the same timed K-state while awake by clearing the send-resume bit after setting it.

Every completed wake-up locks the control registers. They stay locked until a 16-bit unlock key is written. Two interrupt flags record suspend entry and resume completion. Each flag is masked by its own enable bit and cleared by a read-to-clear strobe.

Top module: `usb_susp_ctrl`

## Requirements
- R1: After reset the block is awake: suspend_o=0, osc_en_o=1, clk_gate_o=1, pwroff_o=0, kstate_o=0, int_o=0, flags_o=0, locked_o=0.
- R2: The control register sits at address 0, with go-suspend at bit 0 and send-resume at bit 1. An accepted write that clears bit 0 while bit 0 holds 1 puts the block in suspend from the next cycle: suspend_o=1, osc_en_o=0, clk_gate_o=0. The same write sets flags_o[0]. Writing 0 to a bit that already holds 0 does nothing.
- R3: In suspend, any of these starts the wake sequence at the next clock edge, and osc_en_o then rises: bus_k_i=1, wake_i=1, or cs_ni=0. The cs_ni source counts only if configuration bit 0 (address 2) is set.
- R4: The sequencer moves to awake in the cycle after clk_stable_i is sampled high during the wake sequence. At that point suspend_o falls, clk_gate_o rises and flags_o[1] is set.
- R5: The block is awake no later than WAKE_MAX clock edges after the edge that detected the wake request, even if clk_stable_i never rises.
- R6: For a wake from wake_i or cs_ni, kstate_o is high for exactly KDUR cycles, starting in the cycle suspend_o falls. A wake from the host drives no K-state.
- R7: While awake, an accepted write that clears send-resume (bit 1) after it held 1 drives kstate_o high for exactly KDUR cycles.
- R8: int_o is high when flags_o[0] and enable bit 0 are both set, or when flags_o[1] and enable bit 1 are both set. The enable register sits at address 1. int_clr_i clears both flags; a flag set in the same cycle wins.
- R9: Every wake completion sets locked_o. While locked, writes to addresses 0 to 2 have no effect. Writing 16'hAA37 to address 3 clears locked_o; any other value written there leaves the block locked.
- R10: Wake requests that arrive while a wake sequence is running neither restart nor shorten it.
- R11: pwroff_o is high exactly while suspended, and only when configuration bit 1 (address 2) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 2 | register address |
| wr_data_i | input | DW | write data |
| int_clr_i | input | 1 | read-to-clear strobe for the interrupt flags |
| bus_k_i | input | 1 | host K-state seen on the bus |
| wake_i | input | 1 | application wake pin, active high |
| cs_ni | input | 1 | chip-select, low level may wake |
| clk_stable_i | input | 1 | oscillator and PLL report stable |
| osc_en_o | output | 1 | oscillator and PLL enable |
| clk_gate_o | output | 1 | internal clocks routed to the core |
| suspend_o | output | 1 | device suspended or still waking |
| pwroff_o | output | 1 | powered-off mode active during suspend |
| kstate_o | output | 1 | drive resume K-state on the bus |
| int_o | output | 1 | interrupt request |
| flags_o | output | 2 | bit 0 suspend entered, bit 1 resume done |
| locked_o | output | 1 | control registers write-protected |

## Verification
The bench builds the block with WAKE_MAX=40 and KDUR=25, in place of the millisecond-scale defaults. With these values the full wake timeout and the complete K-state pulse each take a few dozen cycles. The bench can therefore count the exact wake latency and pulse length cycle by cycle. Random clock-stable delays on both sides of the timeout check the min(delay+1, WAKE_MAX) latency rule, over many suspend and wake rounds.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SUSP  = 2'd1,
    ST_OSC   = 2'd2
  } seq_st_e;

  localparam logic [1:0]  A_CTRL = 2'd0;
  localparam logic [1:0]  A_IEN  = 2'd1;
  localparam logic [1:0]  A_CFG  = 2'd2;
  localparam logic [1:0]  A_KEY  = 2'd3;
  localparam logic [15:0] UNLOCK_KEY = 16'hAA37;
  localparam int          NFLAG = 2;
endpackage

// File: rtl/susp_regs.sv
module susp_regs
  import usb_susp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          lock_set_i,
  output logic          locked_o,
  output logic          go_fall_o,
  output logic          rsm_fall_o,
  output logic [1:0]    ien_o,
  output logic [1:0]    cfg_o
);
  logic [1:0] ctrl_q, ien_q, cfg_q;
  logic       locked_q;
  logic       wr_ok, key_hit;

  assign wr_ok   = wr_en_i && !locked_q;
  assign key_hit = wr_en_i && (wr_addr_i == A_KEY) && (wr_data_i[15:0] == UNLOCK_KEY);

  assign go_fall_o  = wr_ok && (wr_addr_i == A_CTRL) && ctrl_q[0] && !wr_data_i[0];
  assign rsm_fall_o = wr_ok && (wr_addr_i == A_CTRL) && ctrl_q[1] && !wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (wr_addr_i)
          A_CTRL:  ctrl_q <= wr_data_i[1:0];
          A_IEN:   ien_q  <= wr_data_i[1:0];
          A_CFG:   cfg_q  <= wr_data_i[1:0];
          default: ;
        endcase
      end
      // lock after wake wins over a same-cycle unlock
      if (lock_set_i)   locked_q <= 1'b1;
      else if (key_hit) locked_q <= 1'b0;
    end
  end

  assign locked_o = locked_q;
  assign ien_o    = ien_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/susp_seq.sv
module susp_seq
  import usb_susp_pkg::*;
#(
  parameter int WAKE_MAX = 720000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_fall_i,
  input  logic    host_k_i,
  input  logic    wake_i,
  input  logic    cs_ni,
  input  logic    cs_wake_en_i,
  input  logic    clk_stable_i,
  output seq_st_e state_o,
  output logic    susp_enter_o,
  output logic    wake_done_o,
  output logic    remote_o
);
  localparam int CW = $clog2(WAKE_MAX + 1);
  localparam logic [CW-1:0] TMO = CW'(WAKE_MAX - 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          remote_q;
  logic          wake_any;

  assign wake_any     = host_k_i || wake_i || (cs_wake_en_i && !cs_ni);
  assign susp_enter_o = (st_q == ST_AWAKE) && go_fall_i;
  assign wake_done_o  = (st_q == ST_OSC) && (clk_stable_i || cnt_q == TMO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_AWAKE;
      cnt_q    <= '0;
      remote_q <= 1'b0;
    end else begin
      case (st_q)
        ST_AWAKE: if (go_fall_i) st_q <= ST_SUSP;
        ST_SUSP: if (wake_any) begin
          st_q     <= ST_OSC;
          cnt_q    <= '0;
          remote_q <= !host_k_i;
        end
        ST_OSC: begin
          if (wake_done_o) st_q  <= ST_AWAKE;
          else             cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_AWAKE;
      endcase
    end
  end

  assign state_o  = st_q;
  assign remote_o = remote_q;
endmodule

// File: rtl/susp_ktimer.sv
module susp_ktimer #(
  parameter int KDUR = 480000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int KW = $clog2(KDUR + 1);
  localparam logic [KW-1:0] KLOAD = KW'(KDUR);

  logic [KW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i && cnt_q == '0)  cnt_q <= KLOAD;
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int WAKE_MAX = 720000,
  parameter int KDUR     = 480000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          int_clr_i,
  input  logic          bus_k_i,
  input  logic          wake_i,
  input  logic          cs_ni,
  input  logic          clk_stable_i,
  output logic          osc_en_o,
  output logic          clk_gate_o,
  output logic          suspend_o,
  output logic          pwroff_o,
  output logic          kstate_o,
  output logic          int_o,
  output logic [1:0]    flags_o,
  output logic          locked_o
);
  seq_st_e          st;
  logic             go_fall, rsm_fall, susp_enter, wake_done, remote;
  logic [1:0]       ien, cfg;
  logic [NFLAG-1:0] flag_set, flag_q;
  logic             k_start;

  susp_regs #(.DW(DW)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .lock_set_i (wake_done),
    .locked_o   (locked_o),
    .go_fall_o  (go_fall),
    .rsm_fall_o (rsm_fall),
    .ien_o      (ien),
    .cfg_o      (cfg)
  );

  susp_seq #(.WAKE_MAX(WAKE_MAX)) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_fall_i    (go_fall),
    .host_k_i     (bus_k_i),
    .wake_i       (wake_i),
    .cs_ni        (cs_ni),
    .cs_wake_en_i (cfg[0]),
    .clk_stable_i (clk_stable_i),
    .state_o      (st),
    .susp_enter_o (susp_enter),
    .wake_done_o  (wake_done),
    .remote_o     (remote)
  );

  assign k_start = (wake_done && remote) || (rsm_fall && st == ST_AWAKE);

  susp_ktimer #(.KDUR(KDUR)) ktim_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (k_start),
    .active_o (kstate_o)
  );

  assign flag_set = {wake_done, susp_enter};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q[g] <= 1'b0;
      else if (flag_set[g]) flag_q[g] <= 1'b1;
      else if (int_clr_i)   flag_q[g] <= 1'b0;
    end
  end

  assign flags_o    = flag_q;
  assign int_o      = |(flag_q & ien);
  assign suspend_o  = (st != ST_AWAKE);
  assign osc_en_o   = (st != ST_SUSP);
  assign clk_gate_o = (st == ST_AWAKE);
  assign pwroff_o   = (st == ST_SUSP) && cfg[1];
endmodule

// File: rtl/susp_chk.sv
module susp_chk #(
  parameter int WAKE_MAX = 720000,
  parameter int KDUR     = 480000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_en_o,
  input logic       clk_gate_o,
  input logic       suspend_o,
  input logic       pwroff_o,
  input logic       kstate_o,
  input logic       int_o,
  input logic [1:0] flags_o,
  input logic       locked_o
);
  localparam int CW = $clog2(WAKE_MAX + 1);
  localparam int KW = $clog2(KDUR + 1);

  logic [CW-1:0] wait_cnt;
  logic [KW-1:0] k_cnt;
  logic          in_wake;

  assign in_wake = suspend_o && osc_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt <= '0;
      k_cnt    <= '0;
    end else begin
      wait_cnt <= in_wake ? wait_cnt + 1'b1 : '0;
      k_cnt    <= kstate_o ? k_cnt + 1'b1 : '0;
    end
  end

  assert_wake_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_wake |-> (wait_cnt < CW'(WAKE_MAX)));

  assert_k_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kstate_o |-> (k_cnt < KW'(KDUR)));

  assert_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_gate_o |-> !suspend_o);

  assert_resume_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(suspend_o) |-> flags_o[1]);

  assert_susp_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_o) |-> flags_o[0]);

  assert_lock_after_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(suspend_o) |-> locked_o);

  assert_pwroff_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwroff_o |-> (suspend_o && !osc_en_o));

  assert_int_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (flags_o != 2'b00));
endmodule

bind usb_susp_ctrl susp_chk #(.WAKE_MAX(WAKE_MAX), .KDUR(KDUR)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_en_o   (osc_en_o),
  .clk_gate_o (clk_gate_o),
  .suspend_o  (suspend_o),
  .pwroff_o   (pwroff_o),
  .kstate_o   (kstate_o),
  .int_o      (int_o),
  .flags_o    (flags_o),
  .locked_o   (locked_o)
);

// File: tb/usb_susp_ctrl_tb_top.sv
module usb_susp_ctrl_tb_top;
  localparam int DW = 16;
  localparam int WM = 40;
  localparam int KD = 25;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          int_clr_i = 1'b0;
  logic          bus_k_i = 1'b0;
  logic          wake_i = 1'b0;
  logic          cs_ni = 1'b1;
  logic          clk_stable_i = 1'b0;
  logic          osc_en_o, clk_gate_o, suspend_o, pwroff_o, kstate_o, int_o, locked_o;
  logic [1:0]    flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  usb_susp_ctrl #(.DW(DW), .WAKE_MAX(WM), .KDUR(KD)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input int d);
    return (d + 1 < WM) ? d + 1 : WM;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic go_suspend();
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0000);
  endtask

  // counts cycles with kstate_o high starting at the current sample point
  task automatic count_k(output int n);
    n = 0;
    while (kstate_o && n < 10 * KD) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic clr_flags();
    @(negedge clk_i); int_clr_i = 1'b1;
    @(negedge clk_i); int_clr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 suspend", suspend_o, 0);
    check("R1 osc", osc_en_o, 1);
    check("R1 gate", clk_gate_o, 1);
    check("R1 k", kstate_o, 0);
    check("R1 int/flags/lock", {int_o, flags_o, locked_o, pwroff_o}, 0);

    // R2 writing 0 to a 0 bit does nothing
    wr(2'd0, 16'h0000);
    check("R2 no edge", suspend_o, 0);

    // R8 enable suspend irq, R11 power-off off
    wr(2'd1, 16'h0001);
    go_suspend();
    check("R2 suspend", suspend_o, 1);
    check("R2 gate off", {osc_en_o, clk_gate_o}, 0);
    check("R2 flag", flags_o, 1);
    check("R8 int susp", int_o, 1);
    check("R11 pwroff off", pwroff_o, 0);
    clr_flags();
    check("R8 clear", {int_o, flags_o}, 0);

    // R3 cs disabled does not wake
    @(negedge clk_i); cs_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R3 cs masked", {suspend_o, osc_en_o}, 2);
    cs_ni = 1'b1;

    // R3 R4 host wake, immediate stable, no K (R6)
    clk_stable_i = 1'b0;
    @(negedge clk_i); bus_k_i = 1'b1;
    @(negedge clk_i); bus_k_i = 1'b0;
    check("R3 osc on", {osc_en_o, suspend_o, clk_gate_o}, 3'b110);
    clk_stable_i = 1'b1;
    @(negedge clk_i);
    check("R4 awake", {suspend_o, clk_gate_o}, 2'b01);
    check("R4 resume flag", flags_o[1], 1);
    check("R8 resume masked", int_o, 0);
    check("R6 host no K", kstate_o, 0);
    check("R9 locked", locked_o, 1);

    // R9 locked writes ignored
    wr(2'd1, 16'h0003);
    check("R9 ien locked", int_o, 0);
    go_suspend();
    check("R9 ctrl locked", suspend_o, 0);
    wr(2'd3, 16'h1234);
    check("R9 bad key", locked_o, 1);
    wr(2'd3, 16'hAA37);
    check("R9 unlock", locked_o, 0);
    wr(2'd1, 16'h0002);
    check("R8 resume int", int_o, 1);
    clr_flags();
    wr(2'd1, 16'h0000);

    // R7 send-resume falling edge
    wr(2'd0, 16'h0002);
    check("R7 no K on set", kstate_o, 0);
    wr(2'd0, 16'h0000);
    count_k(n);
    check("R7 K length", n, KD);

    // R5 R10 timeout with repeated wake, remote K (R6), pwroff (R11)
    wr(2'd2, 16'h0002);
    go_suspend();
    check("R11 pwroff on", pwroff_o, 1);
    clk_stable_i = 1'b0;
    @(negedge clk_i); wake_i = 1'b1;
    @(negedge clk_i); wake_i = 1'b0;
    check("R11 pwroff waking", pwroff_o, 0);
    n = 0;
    while (suspend_o && n < 4 * WM) begin
      wake_i = (n == 5);
      bus_k_i = (n == 9);
      n++;
      @(negedge clk_i);
    end
    wake_i = 1'b0; bus_k_i = 1'b0;
    check("R5 R10 timeout latency", n, WM);
    count_k(n);
    check("R6 remote K length", n, KD);

    // random rounds
    for (int it = 0; it < 30; it++) begin
      int src, d, cfg, lat;
      bit remote;
      src = $urandom_range(0, 2);
      d   = $urandom_range(0, WM + 5);
      cfg = $urandom_range(0, 3);
      if (src == 2) cfg = cfg | 1;
      wr(2'd3, 16'hAA37);
      wr(2'd2, DW'(cfg));
      go_suspend();
      check("R2 rnd suspend", suspend_o, 1);
      check("R11 rnd pwroff", pwroff_o, cfg >> 1);
      clk_stable_i = 1'b0;
      @(negedge clk_i);
      case (src)
        0: bus_k_i = 1'b1;
        1: wake_i = 1'b1;
        default: cs_ni = 1'b0;
      endcase
      @(negedge clk_i);
      bus_k_i = 1'b0; wake_i = 1'b0; cs_ni = 1'b1;
      remote = (src != 0);
      lat = 0;
      while (suspend_o && lat < 4 * WM) begin
        if (lat == d) clk_stable_i = 1'b1;
        lat++;
        @(negedge clk_i);
      end
      check("R4 R5 rnd latency", lat, exp_latency(d));
      check("R6 rnd K start", kstate_o, int'(remote));
      check("R9 rnd lock", locked_o, 1);
      repeat (KD + 2) @(negedge clk_i);
      clr_flags();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule